// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization

This block produces the bit-level timing of a CAN node. A time-quantum enable, made elsewhere by a baud-rate prescaler, advances a quantum counter. Each nominal bit is built from one synchronization quantum, a propagation segment, a first phase segment and a second phase segment. Their lengths come from configuration inputs, which are captured only while the block is disabled. The bus is sampled where the first phase segment ends. The block reports that value with a one-cycle sample strobe and also marks the start of every bit with a transmit-point strobe. The transmitter uses the same sample point to read back each bit it sends.

The block realigns its bit on recessive-to-dominant edges of the receive line. While the bus is idle, such an edge is a start of frame and forces a hard synchronization. The bit restarts at the edge. During a frame, an edge causes a soft resynchronization. An edge that arrives late lengthens the first phase segment, and an edge that arrives early shortens the second phase segment. The jump width caps either move. Only one resynchronization is taken between two sample points, and none is taken while the node itself drives a dominant level. The receive line is taken as already synchronous to the clock.

Top module: `can_bit_timing`

## Requirements
- R1: While enable is low, no strobe is issued and the bit restarts at its synchronization quantum when enable rises. The four length inputs are captured only while enable is low, so changing them while enable is high has no effect on timing. After reset, sampleStb and txPointStb are 0 and sampleBit is 1.
- R2: Timing advances only on clock cycles where tqEn is 1. Each strobe is a single-cycle pulse in the clock cycle after the tqEn cycle that produced it.
- R3: Without edges, a bit lasts 1+prop+ph1+ph2 quanta. sampleStb follows the quantum that is 1+prop+ph1 quanta into the bit. txPointStb follows the last phase-2 quantum, which is the start of the next bit. With 3/8/4 the bit is 16 quanta and the sample point is at quantum 12.
- R4: sampleBit takes the rxLine level present on the tqEn cycle of the sample quantum and holds it until the next sample (1 = recessive, 0 = dominant).
- R5: An edge is present when rxLine is 1 on one tqEn cycle and 0 on the next. An edge in the k-th quantum after the synchronization quantum, before the sample point, lengthens phase 1 by min(k, sjw).
- R6: An edge in the j-th phase-2 quantum has error e = ph2+1-j. If e <= sjw, that quantum becomes the synchronization quantum of a new bit. txPointStb follows it, and the next sample comes prop+ph1 quanta later.
- R7: If e > sjw, phase 2 is shortened by sjw quanta.
- R8: After one resynchronization, further edges are ignored until the next sample point.
- R9: No soft resynchronization occurs while txDominant is 1.
- R10: While busIdle is 1, an edge in any quantum is a hard synchronization. That quantum becomes the synchronization quantum, no txPointStb is issued for it, and it takes priority over soft resynchronization.
- R11: An edge in the synchronization quantum does not move the timing.
- R12: sampleStb and txPointStb are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run when 1; hold and capture configuration when 0 |
| tqEn | input | 1 | Time-quantum enable |
| cfgProp | input | PROP_W | Propagation segment length in quanta |
| cfgPh1 | input | PH1_W | Phase segment 1 length in quanta (at least 1) |
| cfgPh2 | input | PH2_W | Phase segment 2 length in quanta (at least 1) |
| cfgSjw | input | SJW_W | Resynchronization jump width in quanta |
| busIdle | input | 1 | Bus idle; edges cause hard synchronization |
| txDominant | input | 1 | Node is driving a dominant level |
| rxLine | input | 1 | Receive line, 1 recessive, 0 dominant |
| sampleStb | output | 1 | Sample point strobe |
| sampleBit | output | 1 | Last sampled bus value |
| txPointStb | output | 1 | Start-of-bit strobe for the transmitter |

## Verification
The checker verifies on every cycle the properties that need no knowledge of bit position. Strobes only follow a quantum enable and never appear after a disabled cycle. The two strobes never coincide. The sampled value matches the receive line at the sample quantum and holds between samples. Where the sample and transmit points land only shows in the bench's scenarios. Those scenarios cover the nominal bit length, late and early edges inside and beyond the jump width, a second edge before the sample point, edges while transmitting dominant, hard synchronization at idle, and configuration changes while running.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_TSEG1 = 2'd1,
    SEG_PH2   = 2'd2
  } seg_e;

  typedef struct packed {
    logic sample;
    logic txPoint;
  } strobe_t;
endpackage

// File: rtl/cbt_control.sv
module cbt_control #(
  parameter int PROP_W = 4,
  parameter int PH1_W  = 4,
  parameter int PH2_W  = 4,
  parameter int SJW_W  = 3,
  parameter int CNT_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               tqEn,
  input  logic               rxEdge,
  input  logic               busIdle,
  input  logic               txDominant,
  input  logic [PROP_W-1:0]  cfgProp,
  input  logic [PH1_W-1:0]   cfgPh1,
  input  logic [PH2_W-1:0]   cfgPh2,
  input  logic [SJW_W-1:0]   cfgSjw,
  output cbt_pkg::strobe_t   stb
);
  import cbt_pkg::*;

  seg_e             seg, segN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [SJW_W-1:0] ext, extN;
  logic [SJW_W-1:0] cut, cutN;
  logic             resyncDone, resyncDoneN;

  logic [CNT_W-1:0] base, sjwW, ph2W, extAdd, lenEff, errQ, ph2End;
  logic             softOk;

  always_comb begin
    base   = CNT_W'(cfgProp) + CNT_W'(cfgPh1);
    sjwW   = CNT_W'(cfgSjw);
    ph2W   = CNT_W'(cfgPh2);
    softOk = rxEdge && !resyncDone && !txDominant;
    extAdd = (softOk && seg == SEG_TSEG1) ? ((cnt > sjwW) ? sjwW : cnt) : '0;
    lenEff = base + CNT_W'(ext) + extAdd;
    errQ   = ph2W + CNT_W'(1) - cnt;
    ph2End = ph2W - CNT_W'(cut);
  end

  always_comb begin
    segN        = seg;
    cntN        = cnt;
    extN        = ext;
    cutN        = cut;
    resyncDoneN = resyncDone;
    stb         = '0;
    if (!enable) begin
      segN        = SEG_SYNC;
      cntN        = '0;
      extN        = '0;
      cutN        = '0;
      resyncDoneN = 1'b0;
    end else if (tqEn) begin
      if (rxEdge && busIdle) begin
        // hard synchronization: this quantum was the sync quantum
        segN        = SEG_TSEG1;
        cntN        = CNT_W'(1);
        extN        = '0;
        cutN        = '0;
        resyncDoneN = 1'b1;
      end else begin
        unique case (seg)
          SEG_SYNC: begin
            segN = SEG_TSEG1;
            cntN = CNT_W'(1);
            extN = '0;
            cutN = '0;
          end
          SEG_TSEG1: begin
            if (softOk) begin
              resyncDoneN = 1'b1;
              extN        = ext + SJW_W'(extAdd);
            end
            if (cnt >= lenEff) begin
              stb.sample  = 1'b1;
              segN        = SEG_PH2;
              cntN        = CNT_W'(1);
              resyncDoneN = 1'b0;
            end else begin
              cntN = cnt + CNT_W'(1);
            end
          end
          SEG_PH2: begin
            if (softOk && errQ <= sjwW) begin
              // edge quantum becomes the sync quantum of a new bit
              resyncDoneN = 1'b1;
              stb.txPoint = 1'b1;
              segN        = SEG_TSEG1;
              cntN        = CNT_W'(1);
              extN        = '0;
              cutN        = '0;
            end else if (softOk) begin
              resyncDoneN = 1'b1;
              cutN        = cfgSjw;
              if (cnt >= ph2W - sjwW) begin
                stb.txPoint = 1'b1;
                segN        = SEG_SYNC;
                cntN        = '0;
              end else begin
                cntN = cnt + CNT_W'(1);
              end
            end else if (cnt >= ph2End) begin
              stb.txPoint = 1'b1;
              segN        = SEG_SYNC;
              cntN        = '0;
            end else begin
              cntN = cnt + CNT_W'(1);
            end
          end
          default: begin
            segN = SEG_SYNC;
            cntN = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seg        <= SEG_SYNC;
      cnt        <= '0;
      ext        <= '0;
      cut        <= '0;
      resyncDone <= 1'b0;
    end else begin
      seg        <= segN;
      cnt        <= cntN;
      ext        <= extN;
      cut        <= cutN;
      resyncDone <= resyncDoneN;
    end
  end
endmodule

// File: rtl/cbt_datapath.sv
module cbt_datapath #(
  parameter int PROP_W = 4,
  parameter int PH1_W  = 4,
  parameter int PH2_W  = 4,
  parameter int SJW_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               tqEn,
  input  logic               rxLine,
  input  logic [PROP_W-1:0]  cfgPropIn,
  input  logic [PH1_W-1:0]   cfgPh1In,
  input  logic [PH2_W-1:0]   cfgPh2In,
  input  logic [SJW_W-1:0]   cfgSjwIn,
  input  cbt_pkg::strobe_t   stb,
  output logic [PROP_W-1:0]  cfgProp,
  output logic [PH1_W-1:0]   cfgPh1,
  output logic [PH2_W-1:0]   cfgPh2,
  output logic [SJW_W-1:0]   cfgSjw,
  output logic               rxEdge,
  output logic               sampleStb,
  output logic               sampleBit,
  output logic               txPointStb
);
  logic rxPrev;

  // configuration is captured only while disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgProp <= '0;
      cfgPh1  <= PH1_W'(1);
      cfgPh2  <= PH2_W'(1);
      cfgSjw  <= '0;
    end else if (!enable) begin
      cfgProp <= cfgPropIn;
      cfgPh1  <= cfgPh1In;
      cfgPh2  <= cfgPh2In;
      cfgSjw  <= cfgSjwIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rxPrev <= 1'b1;
    else if (!enable) rxPrev <= 1'b1;
    else if (tqEn)    rxPrev <= rxLine;
  end

  assign rxEdge = enable && tqEn && rxPrev && !rxLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleStb  <= 1'b0;
      sampleBit  <= 1'b1;
      txPointStb <= 1'b0;
    end else begin
      sampleStb  <= stb.sample;
      txPointStb <= stb.txPoint;
      if (stb.sample) sampleBit <= rxLine;
    end
  end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
  parameter int PROP_W = 4,
  parameter int PH1_W  = 4,
  parameter int PH2_W  = 4,
  parameter int SJW_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              tqEn,
  input  logic [PROP_W-1:0] cfgProp,
  input  logic [PH1_W-1:0]  cfgPh1,
  input  logic [PH2_W-1:0]  cfgPh2,
  input  logic [SJW_W-1:0]  cfgSjw,
  input  logic              busIdle,
  input  logic              txDominant,
  input  logic              rxLine,
  output logic              sampleStb,
  output logic              sampleBit,
  output logic              txPointStb
);
  localparam int CNT_W = $clog2((1 << PROP_W) + (1 << PH1_W) + (1 << SJW_W) + 1);

  cbt_pkg::strobe_t  stb;
  logic [PROP_W-1:0] propQ;
  logic [PH1_W-1:0]  ph1Q;
  logic [PH2_W-1:0]  ph2Q;
  logic [SJW_W-1:0]  sjwQ;
  logic              rxEdge;

  cbt_datapath #(
    .PROP_W(PROP_W), .PH1_W(PH1_W), .PH2_W(PH2_W), .SJW_W(SJW_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .tqEn(tqEn), .rxLine(rxLine),
    .cfgPropIn(cfgProp), .cfgPh1In(cfgPh1), .cfgPh2In(cfgPh2), .cfgSjwIn(cfgSjw),
    .stb(stb),
    .cfgProp(propQ), .cfgPh1(ph1Q), .cfgPh2(ph2Q), .cfgSjw(sjwQ),
    .rxEdge(rxEdge), .sampleStb(sampleStb), .sampleBit(sampleBit),
    .txPointStb(txPointStb)
  );

  cbt_control #(
    .PROP_W(PROP_W), .PH1_W(PH1_W), .PH2_W(PH2_W), .SJW_W(SJW_W), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .tqEn(tqEn), .rxEdge(rxEdge),
    .busIdle(busIdle), .txDominant(txDominant),
    .cfgProp(propQ), .cfgPh1(ph1Q), .cfgPh2(ph2Q), .cfgSjw(sjwQ),
    .stb(stb)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic tqEn,
  input logic rxLine,
  input logic sampleStb,
  input logic sampleBit,
  input logic txPointStb
);
  // R2: strobes only follow a quantum-enable cycle
  a_r2_strobe_after_tq: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb || txPointStb) |-> $past(tqEn));

  // R1: a disabled cycle produces no strobe
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> (!sampleStb && !txPointStb));

  // R4: sampled value is the line level at the sample quantum
  a_r4_sample_value: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> (sampleBit == $past(rxLine)));

  // R4: sampled value holds between samples
  a_r4_sample_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |-> $stable(sampleBit));

  // R12: the two strobes never coincide
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStb && txPointStb));
endmodule

bind can_bit_timing cbt_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .tqEn(tqEn), .rxLine(rxLine),
  .sampleStb(sampleStb), .sampleBit(sampleBit), .txPointStb(txPointStb)
);

// File: tb/tb_can_bit_timing.sv
module tb_can_bit_timing;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       tqEn = 1'b0;
  logic [3:0] cfgProp = 4'd3;
  logic [3:0] cfgPh1 = 4'd8;
  logic [3:0] cfgPh2 = 4'd4;
  logic [2:0] cfgSjw = 3'd4;
  logic       busIdle = 1'b0;
  logic       txDominant = 1'b0;
  logic       rxLine = 1'b1;
  logic       sampleStb, sampleBit, txPointStb;

  always #5 clk = ~clk;

  can_bit_timing dut (
    .clk(clk), .rstN(rstN), .enable(enable), .tqEn(tqEn),
    .cfgProp(cfgProp), .cfgPh1(cfgPh1), .cfgPh2(cfgPh2), .cfgSjw(cfgSjw),
    .busIdle(busIdle), .txDominant(txDominant), .rxLine(rxLine),
    .sampleStb(sampleStb), .sampleBit(sampleBit), .txPointStb(txPointStb)
  );

  int   checks = 0;
  int   errors = 0;
  logic sched [0:127];
  int   sIdx [0:7];
  logic sVal [0:7];
  int   sCnt;
  int   tIdx [0:7];
  int   tCnt;
  int   curQ;
  bit   prevTq;

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic observe();
    if (sampleStb || txPointStb) begin
      if (!prevTq) check("R2 strobe without quantum enable", 1, 0);
      else begin
        if (sampleStb && sCnt < 8) begin sIdx[sCnt] = curQ; sVal[sCnt] = sampleBit; sCnt++; end
        if (txPointStb && tCnt < 8) begin tIdx[tCnt] = curQ; tCnt++; end
      end
    end
  endtask

  task automatic fillSched(input int fallAt, input int riseAt);
    for (int i = 0; i < 128; i++) sched[i] = !(i >= fallAt && i < riseAt);
  endtask

  task automatic startRun(input int p, input int a, input int b, input int s,
                          input logic idle, input logic txd);
    @(negedge clk);
    enable = 1'b0; tqEn = 1'b0; rxLine = 1'b1;
    cfgProp = 4'(p); cfgPh1 = 4'(a); cfgPh2 = 4'(b); cfgSjw = 3'(s);
    busIdle = idle; txDominant = txd;
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic runQ(input int nq, input int gap);
    sCnt = 0; tCnt = 0; prevTq = 0;
    for (int n = 0; n < nq; n++) begin
      for (int g = 1; g < gap; g++) begin
        @(negedge clk); observe(); tqEn = 1'b0; rxLine = sched[n]; prevTq = 0;
      end
      @(negedge clk); observe(); tqEn = 1'b1; rxLine = sched[n]; curQ = n; prevTq = 1;
    end
    @(negedge clk); observe(); tqEn = 1'b0; prevTq = 0;
  endtask

  task automatic expS(input string req, input int k, input int idx, input int val);
    check({req, " sample quantum"}, (sCnt > k) ? sIdx[k] : -1, idx);
    check({req, " sample value"},   (sCnt > k) ? int'(sVal[k]) : -1, val);
  endtask

  task automatic expT(input string req, input int k, input int idx);
    check({req, " tx point quantum"}, (tCnt > k) ? tIdx[k] : -1, idx);
  endtask

  task automatic t_reset();
    check("R1 reset sampleStb", int'(sampleStb), 0);
    check("R1 reset txPointStb", int'(txPointStb), 0);
    check("R1 reset sampleBit", int'(sampleBit), 1);
  endtask

  task automatic t_disabled();
    int seen = 0;
    enable = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sampleStb || txPointStb) seen++;
      tqEn = 1'b1; rxLine = i[0];
    end
    @(negedge clk);
    if (sampleStb || txPointStb) seen++;
    tqEn = 1'b0; rxLine = 1'b1;
    check("R1 no strobes while disabled", seen, 0);
  endtask

  task automatic t_nominal();
    startRun(3, 8, 4, 4, 1'b0, 1'b0);
    fillSched(999, 999);
    cfgProp = 4'd1; cfgPh1 = 4'd2; cfgPh2 = 4'd1; // ignored while enabled (R1)
    runQ(34, 1);
    expS("R3 nominal", 0, 11, 1);
    expS("R1 config held", 1, 27, 1);
    expT("R3 nominal", 0, 15);
    expT("R3 nominal", 1, 31);
  endtask

  task automatic t_slowQuantum();
    startRun(3, 8, 4, 4, 1'b0, 1'b0);
    fillSched(999, 999);
    runQ(30, 3);
    expS("R2 slow quantum", 0, 11, 1);
    expS("R2 slow quantum", 1, 27, 1);
    expT("R2 slow quantum", 0, 15);
  endtask

  task automatic t_syncEdge();
    startRun(3, 8, 4, 4, 1'b0, 1'b0);
    fillSched(16, 32);
    runQ(46, 1);
    expS("R11 edge in sync", 1, 27, 0);
    expS("R4 value", 2, 43, 1);
  endtask

  task automatic t_lateEdge();
    startRun(3, 8, 4, 4, 1'b0, 1'b0);
    fillSched(18, 999);
    runQ(48, 1);
    expS("R5 late edge", 1, 29, 0);
    expT("R5 late edge", 1, 33);
    expS("R5 late edge", 2, 45, 0);
  endtask

  task automatic t_lateClip();
    startRun(3, 8, 4, 4, 1'b0, 1'b0);
    fillSched(23, 999);
    runQ(50, 1);
    expS("R5 late edge clipped", 1, 31, 0);
    expT("R5 late edge clipped", 1, 35);
    expS("R5 late edge clipped", 2, 47, 0);
  endtask

  task automatic t_earlyEdge();
    startRun(3, 8, 4, 4, 1'b0, 1'b0);
    fillSched(30, 999);
    runQ(44, 1);
    expS("R6 early edge", 1, 27, 1);
    expT("R6 early edge", 1, 30);
    expS("R6 early edge", 2, 41, 0);
  endtask

  task automatic t_earlyClip();
    startRun(3, 6, 6, 2, 1'b0, 1'b0);
    fillSched(27, 999);
    runQ(42, 1);
    expS("R7 early edge clipped", 0, 9, 1);
    expT("R7 early edge clipped", 0, 15);
    expT("R7 early edge clipped", 1, 29);
    expS("R7 early edge clipped", 2, 39, 0);
  endtask

  task automatic t_oneResync();
    startRun(3, 8, 4, 4, 1'b0, 1'b0);
    fillSched(18, 999);
    sched[19] = 1'b1; sched[20] = 1'b1;
    runQ(32, 1);
    expS("R8 second edge ignored", 1, 29, 0);
  endtask

  task automatic t_txDominant();
    startRun(3, 8, 4, 4, 1'b0, 1'b1);
    fillSched(18, 999);
    runQ(32, 1);
    expS("R9 no resync while driving", 1, 27, 0);
    expT("R9 no resync while driving", 1, 31);
  endtask

  task automatic t_hardSync();
    startRun(3, 8, 4, 4, 1'b1, 1'b0);
    fillSched(22, 999);
    runQ(40, 1);
    expT("R10 hard sync", 0, 15);
    expS("R10 hard sync", 1, 33, 0);
    expT("R10 hard sync no extra tx point", 1, 37);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_nominal();
    t_slowQuantum();
    t_syncEdge();
    t_lateEdge();
    t_lateClip();
    t_earlyEdge();
    t_earlyClip();
    t_oneResync();
    t_txDominant();
    t_hardSync();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule